// File: doc/BRIEF.md
# FIFO ready flag generator

This block drives the two active-low ready strobes of one serial channel. A DMA engine or a host handshake uses these strobes to move data in and out of the channel's 64-entry receive and transmit queues. The queues, the receive timeout counter and the serial engines sit outside the block. The block sees only their fill counts, a timeout pulse and an error flag, together with two programmable trigger levels.

The receive strobe goes low once enough data is waiting or once the timeout fires. It stays low until the receive queue drains to empty or an error is flagged. The transmit strobe works on free space, which is the queue depth minus the transmit fill count. It goes low once the free space reaches its trigger and stays low until the transmit queue is full. When a release condition and an assert condition meet in the same cycle, the release wins. Both strobes are registered and change one clock after their cause.

Top module: `fifo_rdy_flags`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, both `rx_rdy_n` and `tx_rdy_n` read 1. This holds whatever the other inputs are.
- R2: With `rx_err` low and `rx_level` nonzero, a receive fill at or above `rx_trig` drives `rx_rdy_n` to 0. A fill below `rx_trig` does not drive it low.
- R3: A one-cycle `rx_tmo` pulse drives `rx_rdy_n` to 0 even when the fill is below `rx_trig`, provided `rx_level` is nonzero and `rx_err` is low.
- R4: Once `rx_rdy_n` is 0, it stays 0 while `rx_level` is nonzero and `rx_err` is low, even if the fill falls below `rx_trig`.
- R5: An `rx_level` of 0 drives `rx_rdy_n` to 1.
- R6: `rx_err` high drives `rx_rdy_n` to 1.
- R7: When a receive release condition (empty or error) and an assert condition (trigger or timeout) occur in the same cycle, `rx_rdy_n` goes to 1. This includes `rx_trig` = 0 with an empty queue.
- R8: Free space is 64 minus `tx_level`. With the queue not full, free space at or above `tx_trig` drives `tx_rdy_n` to 0.
- R9: A `tx_level` of 64 (full) drives `tx_rdy_n` to 1. This holds even when `tx_trig` is 0.
- R10: When neither a transmit assert nor a release condition is present, `tx_rdy_n` keeps its previous value, whether that value is 0 or 1.
- R11: Each output changes on the clock edge that samples its cause. It still shows the old value before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_level | input | 7 | Receive queue fill count, 0 to 64 |
| rx_trig | input | 7 | Receive trigger level |
| rx_tmo | input | 1 | Receive timeout pulse, one cycle |
| rx_err | input | 1 | An errored entry is present in the receive queue |
| tx_level | input | 7 | Transmit queue fill count, 0 to 64 |
| tx_trig | input | 7 | Transmit free-space trigger level |
| rx_rdy_n | output | 1 | Receive ready, active low, registered |
| tx_rdy_n | output | 1 | Transmit ready, active low, registered |

## Verification
Two cases can land in the same cycle: the receive assert path (threshold or timeout) and the receive release path (empty or error). On the transmit side, a zero trigger collides with a full queue in the same way. The bench provokes these collisions directly. It raises a timeout pulse together with the error flag, it sets a zero receive trigger against an empty queue, and it sets a zero transmit trigger against a full queue. In each case the strobe must read 1 one cycle later. The bench then removes the release cause alone and checks that the strobe asserts, which shows the earlier high was the priority rule at work and not a missing assert path.

// File: rtl/fifo_rdy_pkg.sv
package fifo_rdy_pkg;

  // Action a condition unit requests from a flag register.
  typedef enum logic [1:0] {
    RDY_HOLD    = 2'd0,
    RDY_ASSERT  = 2'd1,
    RDY_RELEASE = 2'd2
  } rdy_act_e;

  // Release always outranks assert.
  function automatic rdy_act_e rdy_pick(input logic rel, input logic set);
    if (rel)      return RDY_RELEASE;
    else if (set) return RDY_ASSERT;
    else          return RDY_HOLD;
  endfunction

endpackage

// File: rtl/fifo_rdy_rx_cond.sv
module fifo_rdy_rx_cond
  import fifo_rdy_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] trig,
  input  logic          tmo,
  input  logic          err,
  output rdy_act_e      act
);

  logic is_empty;
  logic at_trig;
  logic rel;
  logic set;

  always_comb begin
    is_empty = (level == '0);
    at_trig  = (level >= trig);
    rel      = is_empty | err;
    set      = at_trig | tmo;
    act      = rdy_pick(rel, set);
  end

endmodule

// File: rtl/fifo_rdy_tx_cond.sv
module fifo_rdy_tx_cond
  import fifo_rdy_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] trig,
  output rdy_act_e      act
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic          is_full;
  logic [CW-1:0] space;
  logic          rel;
  logic          set;

  always_comb begin
    is_full = (level >= FULL);
    // Saturate so an out-of-range count reads as no space.
    space   = is_full ? '0 : (FULL - level);
    rel     = is_full;
    set     = (space >= trig);
    act     = rdy_pick(rel, set);
  end

endmodule

// File: rtl/fifo_rdy_flag_reg.sv
module fifo_rdy_flag_reg
  import fifo_rdy_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rdy_act_e act,
  output logic     flag_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n <= 1'b1;
    end else begin
      unique case (act)
        RDY_RELEASE: flag_n <= 1'b1;
        RDY_ASSERT:  flag_n <= 1'b0;
        default:     flag_n <= flag_n;
      endcase
    end
  end

endmodule

// File: rtl/fifo_rdy_flags.sv
module fifo_rdy_flags
  import fifo_rdy_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] rx_trig,
  input  logic          rx_tmo,
  input  logic          rx_err,
  input  logic [CW-1:0] tx_level,
  input  logic [CW-1:0] tx_trig,
  output logic          rx_rdy_n,
  output logic          tx_rdy_n
);

  localparam int NFLAG = 2;

  rdy_act_e act [NFLAG];
  logic     flg [NFLAG];

  fifo_rdy_rx_cond #(.DEPTH(DEPTH)) i_rx_cond (
    .level (rx_level),
    .trig  (rx_trig),
    .tmo   (rx_tmo),
    .err   (rx_err),
    .act   (act[0])
  );

  fifo_rdy_tx_cond #(.DEPTH(DEPTH)) i_tx_cond (
    .level (tx_level),
    .trig  (tx_trig),
    .act   (act[1])
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    fifo_rdy_flag_reg i_reg (
      .clk    (clk),
      .rst    (rst),
      .act    (act[g]),
      .flag_n (flg[g])
    );
  end

  assign rx_rdy_n = flg[0];
  assign tx_rdy_n = flg[1];

endmodule

// File: rtl/fifo_rdy_flags_chk.sv
module fifo_rdy_flags_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] rx_level,
  input logic [CW-1:0] rx_trig,
  input logic          rx_tmo,
  input logic          rx_err,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] tx_trig,
  input logic          rx_rdy_n,
  input logic          tx_rdy_n
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= rst;

  // R1: the cycle after a reset cycle shows both strobes released.
  always_comb begin
    if (rst_seen_q === 1'b1) begin
      a_r1_reset_high: assert (rx_rdy_n && tx_rdy_n);
    end
  end

  a_r2_trig_sets: assert property (@(posedge clk) disable iff (rst)
    (rx_level >= rx_trig && rx_level != '0 && !rx_err) |=> !rx_rdy_n);

  a_r3_tmo_sets: assert property (@(posedge clk) disable iff (rst)
    (rx_tmo && rx_level != '0 && !rx_err) |=> !rx_rdy_n);

  a_r4_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (!rx_rdy_n && rx_level != '0 && !rx_err) |=> !rx_rdy_n);

  a_r5_empty_clears: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |=> rx_rdy_n);

  a_r6_err_clears: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> rx_rdy_n);

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    ((rx_tmo || rx_level >= rx_trig) && (rx_err || rx_level == '0)) |=> rx_rdy_n);

  a_r8_space_sets: assert property (@(posedge clk) disable iff (rst)
    (tx_level < FULL && (FULL - tx_level) >= tx_trig) |=> !tx_rdy_n);

  a_r9_full_clears: assert property (@(posedge clk) disable iff (rst)
    (tx_level >= FULL) |=> tx_rdy_n);

  a_r10_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (!tx_rdy_n && tx_level < FULL) |=> !tx_rdy_n);

endmodule

bind fifo_rdy_flags fifo_rdy_flags_chk #(.DEPTH(DEPTH)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_level (rx_level),
  .rx_trig  (rx_trig),
  .rx_tmo   (rx_tmo),
  .rx_err   (rx_err),
  .tx_level (tx_level),
  .tx_trig  (tx_trig),
  .rx_rdy_n (rx_rdy_n),
  .tx_rdy_n (tx_rdy_n)
);

// File: tb/test_fifo_rdy_flags.sv
`timescale 1ns/1ps
module test_fifo_rdy_flags;

  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic [CW-1:0] rx_level, rx_trig, tx_level, tx_trig;
  logic          rx_tmo, rx_err;
  logic          rx_rdy_n, tx_rdy_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fifo_rdy_flags #(.DEPTH(DEPTH)) i_fifo_rdy_flags (
    .clk      (clk),
    .rst      (rst),
    .rx_level (rx_level),
    .rx_trig  (rx_trig),
    .rx_tmo   (rx_tmo),
    .rx_err   (rx_err),
    .tx_level (tx_level),
    .tx_trig  (tx_trig),
    .rx_rdy_n (rx_rdy_n),
    .tx_rdy_n (tx_rdy_n)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // Drive receive inputs after a falling edge, then wait one full cycle.
  task automatic rx_step(input int lvl, input int trg, input logic tmo, input logic err);
    @(negedge clk);
    rx_level = CW'(lvl);
    rx_trig  = CW'(trg);
    rx_tmo   = tmo;
    rx_err   = err;
    @(negedge clk);
  endtask

  task automatic tx_step(input int lvl, input int trg);
    @(negedge clk);
    tx_level = CW'(lvl);
    tx_trig  = CW'(trg);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    rx_level = 7'd20; rx_trig = 7'd8; rx_tmo = 1'b1; rx_err = 1'b0;
    tx_level = 7'd0;  tx_trig = 7'd16;
    @(negedge clk);
    @(negedge clk);
    chk("R1 rx in reset", rx_rdy_n, 1'b1);
    chk("R1 tx in reset", tx_rdy_n, 1'b1);
    rx_level = 7'd0; rx_tmo = 1'b0; tx_level = 7'd64;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rx after reset", rx_rdy_n, 1'b1);
    chk("R1 tx after reset", tx_rdy_n, 1'b1);
  endtask

  task automatic t_rx_trigger;
    rx_step(7, 8, 1'b0, 1'b0);
    chk("R2 below trigger", rx_rdy_n, 1'b1);
    rx_step(8, 8, 1'b0, 1'b0);
    chk("R2 at trigger", rx_rdy_n, 1'b0);
    rx_step(0, 8, 1'b0, 1'b0);
    chk("R5 empty releases", rx_rdy_n, 1'b1);
  endtask

  task automatic t_rx_timeout;
    rx_step(3, 8, 1'b1, 1'b0);
    chk("R3 timeout asserts", rx_rdy_n, 1'b0);
    rx_step(3, 8, 1'b0, 1'b0);
    chk("R4 held after pulse", rx_rdy_n, 1'b0);
    rx_step(1, 8, 1'b0, 1'b0);
    chk("R4 held while draining", rx_rdy_n, 1'b0);
    rx_step(0, 8, 1'b0, 1'b0);
    chk("R5 drained releases", rx_rdy_n, 1'b1);
  endtask

  task automatic t_rx_error;
    rx_step(20, 8, 1'b0, 1'b0);
    chk("R2 above trigger", rx_rdy_n, 1'b0);
    rx_step(20, 8, 1'b0, 1'b1);
    chk("R6 error releases", rx_rdy_n, 1'b1);
    rx_step(20, 8, 1'b0, 1'b1);
    chk("R7 error beats threshold", rx_rdy_n, 1'b1);
    rx_step(20, 8, 1'b0, 1'b0);
    chk("R2 reasserts after error", rx_rdy_n, 1'b0);
    rx_step(0, 8, 1'b0, 1'b0);
  endtask

  task automatic t_rx_conflict;
    rx_step(2, 8, 1'b1, 1'b1);
    chk("R7 timeout with error", rx_rdy_n, 1'b1);
    rx_step(2, 8, 1'b1, 1'b0);
    chk("R3 timeout alone", rx_rdy_n, 1'b0);
    rx_step(0, 0, 1'b0, 1'b0);
    chk("R7 zero trigger empty", rx_rdy_n, 1'b1);
    rx_step(1, 0, 1'b0, 1'b0);
    chk("R2 zero trigger one entry", rx_rdy_n, 1'b0);
    rx_step(0, 8, 1'b0, 1'b0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    rx_level = 7'd8; rx_trig = 7'd8; rx_tmo = 1'b0; rx_err = 1'b0;
    #1;
    chk("R11 rx before edge", rx_rdy_n, 1'b1);
    @(negedge clk);
    chk("R11 rx after edge", rx_rdy_n, 1'b0);
    rx_step(0, 8, 1'b0, 1'b0);
  endtask

  task automatic t_tx;
    tx_step(49, 16);
    chk("R10 stays high, free 15", tx_rdy_n, 1'b1);
    tx_step(48, 16);
    chk("R8 free 16 asserts", tx_rdy_n, 1'b0);
    tx_step(60, 16);
    chk("R10 stays low, free 4", tx_rdy_n, 1'b0);
    tx_step(64, 16);
    chk("R9 full releases", tx_rdy_n, 1'b1);
    tx_step(64, 0);
    chk("R9 full beats zero trigger", tx_rdy_n, 1'b1);
    tx_step(63, 0);
    chk("R8 zero trigger not full", tx_rdy_n, 1'b0);
    tx_step(64, 64);
    chk("R9 full again", tx_rdy_n, 1'b1);
    tx_step(0, 64);
    chk("R8 empty queue trigger 64", tx_rdy_n, 1'b0);
    tx_step(1, 64);
    chk("R10 hold at free 63", tx_rdy_n, 1'b0);
  endtask

  initial begin
    rst = 1'b1;
    rx_level = '0; rx_trig = 7'd8; rx_tmo = 1'b0; rx_err = 1'b0;
    tx_level = 7'd64; tx_trig = 7'd16;
    t_reset();
    t_rx_trigger();
    t_rx_timeout();
    t_rx_error();
    t_rx_conflict();
    t_latency();
    t_tx();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule